// File: doc/BRIEF.md
# I2C Slave Address Matcher with Mask

This block sits behind the SCL/SDA pad logic of an I2C target and decides, during the address phase of each transfer, whether the target answers. It receives SDA values already sampled on rising SCL, one strobe per bit, plus start and stop indications. It assembles the first address byte and, in 10-bit mode, the second byte. It compares them with a programmed own address. A per-bit mask can mark any address bit as don't-care.

Some I2C addresses are reserved, and no mask setting can turn them into a normal match. The general call address is accepted only when it is enabled. A 10-bit read is opened by a repeated start that carries the upper byte again with R/W = 1. That read is accepted only after a matched 10-bit write. The ACK decision is registered as the eighth bit arrives, and the block pulls SDA low for the ninth bit only on acceptance.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset all outputs are 0. Bits that arrive before the first start condition are ignored: a byte equal to the own address, sent without a start, gives no ACK and no match.
- R2: In 7-bit mode (`ten_mode`=0) with a zero mask, a first byte {A[6:0], RW} whose A equals `own_addr[6:0]` is acknowledged. It sets `addr_match`, and `rw_flag` takes bit 0 of that byte. Any other A is not acknowledged.
- R3: A mask bit of 1 makes the matching address bit a don't-care. A mask bit of 0 requires equality. With own 1010000 and only mask bit 5 set, both 1010000 and 1110000 match and 1010001 does not.
- R4: While `mask_off`=1 the mask is treated as all zeros, so only exact addresses match.
- R5: In 7-bit mode, addresses of the form 0000xxx or 1111xxx never give an own-address match, even when the own address equals them and the mask is all ones. The start byte (0000000 with RW=1) is never acknowledged.
- R6: The first byte 0x00 (general call) is acknowledged, with `gc_hit`=1 and `addr_match`=0, only when `gc_en`=1. With `gc_en`=0 it is not acknowledged.
- R7: In 10-bit mode, a first byte 11110 a9 a8 0 whose a9..a8 match `own_addr[9:8]` is acknowledged without setting `addr_match`. A following byte equal to `own_addr[7:0]` is then acknowledged and sets `addr_match`. The mask applies to all 10 bits.
- R8: In 10-bit mode, first bytes 11111xx and 0000xxx (other than the general call) are never acknowledged. In 7-bit mode, 11110xx is never acknowledged.
- R9: After a matched 10-bit write, a repeated start followed by the same upper byte with RW=1 is acknowledged, with `addr_match`=1 and `rw_flag`=1. Without a prior matched write, that byte is not acknowledged.
- R10: `sda_pull` rises at the clock edge that takes in the eighth bit of an accepted byte and falls at the edge that takes in the ninth bit.
- R11: A start or stop condition clears `addr_match`, `gc_hit`, `rw_flag`, `sda_pull` and any partly received byte. A stop also forgets a matched 10-bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | One-cycle strobe: a sampled SDA bit is present |
| bit_val | input | 1 | Sampled SDA value, MSB first |
| start_det | input | 1 | Start or repeated start condition seen |
| stop_det | input | 1 | Stop condition seen |
| ten_mode | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| addr_mask | input | 10 | 1 marks an address bit as don't-care |
| mask_off | input | 1 | 1 disables masking |
| gc_en | input | 1 | Enables general call acceptance |
| addr_match | output | 1 | Own address fully matched in this transfer |
| sda_pull | output | 1 | Drive SDA low (ACK) |
| gc_hit | output | 1 | General call accepted |
| rw_flag | output | 1 | R/W bit of the accepted address |

## Verification
The own-address path is tried with exact hits, single-bit misses and reads, so that the compare is separated from the R/W capture. Masked patterns show that a don't-care bit accepts both values and that an unmasked neighbour still rejects. The same masked pattern with masking disabled shows that the disable takes priority. Reserved, start-byte and general-call patterns are sent with a permissive mask to show that the filter overrides the mask. The 10-bit sequences tell apart an upper-byte ACK, a full match, a low-byte miss, and a repeated-start read with and without a prior write. Interrupted bytes and stray bits after a stop show that the clearing works.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int A7_W   = 7;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int PFX_W  = BYTE_W - HI_W - 1;

    localparam logic [PFX_W-1:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        PH_IGNORE,
        PH_FIRST,
        PH_LOW,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic own7;
        logic gcall;
        logic upper;
        logic rw;
    } first_cls_t;

    function automatic logic rsv7(input logic [A7_W-1:0] a);
        return (a[A7_W-1 -: 4] == 4'h0) || (a[A7_W-1 -: 4] == 4'hF);
    endfunction

endpackage

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_val,
    output logic [BYTE_W-1:0] byte_nxt,
    output logic              last_bit,
    output logic              ack_bit
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    assign byte_nxt = {sh_q[BYTE_W-2:0], bit_val};
    assign last_bit = bit_vld && (cnt_q == LAST_IDX);
    assign ack_bit  = bit_vld && (cnt_q == ACK_IDX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (bit_vld) begin
            if (cnt_q == ACK_IDX) begin
                cnt_q <= '0;
            end else begin
                sh_q  <= byte_nxt;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= ACK_IDX);

    a_r11_clr_restarts: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ten_mode,
    input  logic              gc_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] eff_mask,
    output first_cls_t        cls,
    output logic              low_hit
);

    logic [ADDR_W-1:0] bit_ok_first;
    logic [BYTE_W-1:0] bit_ok_low;
    logic [A7_W-1:0]   a7;

    assign a7 = byte_in[BYTE_W-1:1];

    for (genvar i = 0; i < A7_W; i++) begin : g_first7
        assign bit_ok_first[i] = eff_mask[i] || (a7[i] == own_addr[i]);
    end
    for (genvar i = 0; i < HI_W; i++) begin : g_first_hi
        assign bit_ok_first[BYTE_W+i] = eff_mask[BYTE_W+i] || (byte_in[1+i] == own_addr[BYTE_W+i]);
    end
    assign bit_ok_first[BYTE_W-1] = 1'b1;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_low
        assign bit_ok_low[i] = eff_mask[i] || (byte_in[i] == own_addr[i]);
    end

    always_comb begin
        cls       = '0;
        cls.rw    = byte_in[0];
        cls.gcall = gc_en && (byte_in == '0);
        cls.own7  = !ten_mode && !rsv7(a7) && (&bit_ok_first[A7_W-1:0]);
        cls.upper = ten_mode && (byte_in[BYTE_W-1 -: PFX_W] == TEN_PREFIX)
                    && (&bit_ok_first[ADDR_W-1:BYTE_W]);
    end

    assign low_hit = &bit_ok_low;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              ten_mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              mask_off,
    input  logic              gc_en,
    output logic              addr_match,
    output logic              sda_pull,
    output logic              gc_hit,
    output logic              rw_flag
);

    logic [BYTE_W-1:0] byte_nxt;
    logic              last_bit;
    logic              ack_bit;
    logic [ADDR_W-1:0] eff_mask;
    first_cls_t        cls;
    logic              low_hit;
    phase_e            phase_q;
    logic              wr10_ok_q;

    assign eff_mask = mask_off ? '0 : addr_mask;

    i2c_am_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_det || stop_det),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .byte_nxt (byte_nxt),
        .last_bit (last_bit),
        .ack_bit  (ack_bit)
    );

    i2c_am_cmp u_cmp (
        .byte_in  (byte_nxt),
        .ten_mode (ten_mode),
        .gc_en    (gc_en),
        .own_addr (own_addr),
        .eff_mask (eff_mask),
        .cls      (cls),
        .low_hit  (low_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IGNORE;
            wr10_ok_q  <= 1'b0;
            addr_match <= 1'b0;
            sda_pull   <= 1'b0;
            gc_hit     <= 1'b0;
            rw_flag    <= 1'b0;
        end else if (start_det) begin
            phase_q    <= PH_FIRST;
            addr_match <= 1'b0;
            sda_pull   <= 1'b0;
            gc_hit     <= 1'b0;
            rw_flag    <= 1'b0;
        end else if (stop_det) begin
            phase_q    <= PH_IGNORE;
            wr10_ok_q  <= 1'b0;
            addr_match <= 1'b0;
            sda_pull   <= 1'b0;
            gc_hit     <= 1'b0;
            rw_flag    <= 1'b0;
        end else begin
            if (ack_bit) begin
                sda_pull <= 1'b0;
            end
            if (last_bit) begin
                unique case (phase_q)
                    PH_FIRST: begin
                        wr10_ok_q <= 1'b0;
                        phase_q   <= PH_IGNORE;
                        if (cls.upper && !cls.rw) begin
                            sda_pull <= 1'b1;
                            phase_q  <= PH_LOW;
                        end else if (cls.upper && cls.rw && wr10_ok_q) begin
                            sda_pull   <= 1'b1;
                            addr_match <= 1'b1;
                            rw_flag    <= 1'b1;
                            phase_q    <= PH_DONE;
                        end else if (cls.gcall) begin
                            sda_pull <= 1'b1;
                            gc_hit   <= 1'b1;
                            phase_q  <= PH_DONE;
                        end else if (cls.own7) begin
                            sda_pull   <= 1'b1;
                            addr_match <= 1'b1;
                            rw_flag    <= cls.rw;
                            phase_q    <= PH_DONE;
                        end
                    end
                    PH_LOW: begin
                        if (low_hit) begin
                            sda_pull   <= 1'b1;
                            addr_match <= 1'b1;
                            wr10_ok_q  <= 1'b1;
                            phase_q    <= PH_DONE;
                        end else begin
                            phase_q <= PH_IGNORE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r10_ack_on_eighth: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(last_bit));

    a_r10_ack_release: assert property (@(posedge clk) disable iff (rst)
        (sda_pull && ack_bit && !start_det) |=> !sda_pull);

    a_r11_clear_on_cond: assert property (@(posedge clk) disable iff (rst)
        (start_det || stop_det) |=> (!addr_match && !gc_hit && !sda_pull && !rw_flag));

    a_r6_gc_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(gc_hit) |-> $past(gc_en));

    a_r6_gc_not_own: assert property (@(posedge clk) disable iff (rst)
        !(gc_hit && addr_match));

    a_r9_read_flag: assert property (@(posedge clk) disable iff (rst)
        ($rose(addr_match) && ten_mode && $past(phase_q == PH_FIRST)) |-> rw_flag);

endmodule

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_val = 1'b0;
    logic       start_det = 1'b0;
    logic       stop_det = 1'b0;
    logic       ten_mode = 1'b0;
    logic [9:0] own_addr = '0;
    logic [9:0] addr_mask = '0;
    logic       mask_off = 1'b0;
    logic       gc_en = 1'b0;
    logic       addr_match, sda_pull, gc_hit, rw_flag;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    i2c_addr_match u0 (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
        .start_det(start_det), .stop_det(stop_det), .ten_mode(ten_mode),
        .own_addr(own_addr), .addr_mask(addr_mask), .mask_off(mask_off),
        .gc_en(gc_en), .addr_match(addr_match), .sda_pull(sda_pull),
        .gc_hit(gc_hit), .rw_flag(rw_flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_val = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic do_start();
        @(negedge clk);
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_det = 1'b1;
        @(negedge clk);
        stop_det = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 match after reset", addr_match, 1'b0);
        chk("R1 pull after reset", sda_pull, 1'b0);
        chk("R1 gc after reset", gc_hit, 1'b0);
        chk("R1 rw after reset", rw_flag, 1'b0);
        own_addr = 10'h02A;
        send_byte(8'h54);
        chk("R1 no ack before start", sda_pull, 1'b0);
        chk("R1 no match before start", addr_match, 1'b0);
    endtask

    task automatic t_seven_exact();
        own_addr = 10'h02A; addr_mask = '0; ten_mode = 1'b0;
        do_start(); send_byte(8'h54);
        chk("R2 ack own write", sda_pull, 1'b1);
        chk("R2 match own write", addr_match, 1'b1);
        chk("R2 rw write", rw_flag, 1'b0);
        chk("R10 ack high on eighth", sda_pull, 1'b1);
        send_bit(1'b0);
        chk("R10 ack released on ninth", sda_pull, 1'b0);
        chk("R2 match held", addr_match, 1'b1);
        do_start(); send_byte(8'h55);
        chk("R2 ack own read", sda_pull, 1'b1);
        chk("R2 rw read", rw_flag, 1'b1);
        do_start(); send_byte(8'h56);
        chk("R2 other address nack", sda_pull, 1'b0);
        chk("R2 other address no match", addr_match, 1'b0);
    endtask

    task automatic t_mask();
        own_addr = 10'h050; addr_mask = 10'h020; mask_off = 1'b0;
        do_start(); send_byte(8'hA0);
        chk("R3 masked bit as 0", addr_match, 1'b1);
        do_start(); send_byte(8'hE0);
        chk("R3 masked bit as 1", addr_match, 1'b1);
        do_start(); send_byte(8'hA2);
        chk("R3 unmasked bit differs", sda_pull, 1'b0);
    endtask

    task automatic t_mask_off();
        own_addr = 10'h050; addr_mask = 10'h020; mask_off = 1'b1;
        do_start(); send_byte(8'hE0);
        chk("R4 mask disabled rejects", sda_pull, 1'b0);
        do_start(); send_byte(8'hA0);
        chk("R4 mask disabled exact ok", addr_match, 1'b1);
        mask_off = 1'b0;
    endtask

    task automatic t_reserved();
        addr_mask = 10'h3FF; gc_en = 1'b0;
        own_addr = 10'h07C;
        do_start(); send_byte(8'hF8);
        chk("R5 1111xxx rejected", sda_pull, 1'b0);
        own_addr = 10'h004;
        do_start(); send_byte(8'h08);
        chk("R5 00001xx rejected", sda_pull, 1'b0);
        do_start(); send_byte(8'h02);
        chk("R5 cbus rejected", addr_match, 1'b0);
        gc_en = 1'b1;
        do_start(); send_byte(8'h01);
        chk("R5 start byte nack", sda_pull, 1'b0);
        chk("R5 start byte no gc", gc_hit, 1'b0);
        gc_en = 1'b0; addr_mask = '0;
    endtask

    task automatic t_gcall();
        own_addr = 10'h02A;
        gc_en = 1'b0;
        do_start(); send_byte(8'h00);
        chk("R6 gc disabled nack", sda_pull, 1'b0);
        chk("R6 gc disabled flag", gc_hit, 1'b0);
        gc_en = 1'b1;
        do_start(); send_byte(8'h00);
        chk("R6 gc enabled ack", sda_pull, 1'b1);
        chk("R6 gc enabled flag", gc_hit, 1'b1);
        chk("R6 gc no own match", addr_match, 1'b0);
        gc_en = 1'b0;
    endtask

    task automatic t_ten_bit();
        ten_mode = 1'b1; own_addr = 10'h2B5; addr_mask = '0;
        do_start(); send_byte(8'hF4);
        chk("R7 upper ack", sda_pull, 1'b1);
        chk("R7 upper no match yet", addr_match, 1'b0);
        send_bit(1'b0);
        send_byte(8'hB5);
        chk("R7 low ack", sda_pull, 1'b1);
        chk("R7 full match", addr_match, 1'b1);
        do_start(); send_byte(8'hF4); send_bit(1'b0); send_byte(8'hB4);
        chk("R7 low miss", addr_match, 1'b0);
        addr_mask = 10'h001;
        do_start(); send_byte(8'hF4); send_bit(1'b0); send_byte(8'hB4);
        chk("R7 low masked", addr_match, 1'b1);
        addr_mask = 10'h200;
        do_start(); send_byte(8'hF0);
        chk("R7 upper masked a9", sda_pull, 1'b1);
        addr_mask = '0;
        do_start(); send_byte(8'hF0);
        chk("R7 upper miss", sda_pull, 1'b0);
        do_stop();
    endtask

    task automatic t_ten_reserved();
        ten_mode = 1'b1; addr_mask = 10'h3FF; own_addr = 10'h3FF;
        do_start(); send_byte(8'hF8);
        chk("R8 11111xx in 10-bit", sda_pull, 1'b0);
        do_start(); send_byte(8'h08);
        chk("R8 0000xxx in 10-bit", sda_pull, 1'b0);
        ten_mode = 1'b0; addr_mask = '0; own_addr = 10'h07A;
        do_start(); send_byte(8'hF4);
        chk("R8 11110xx in 7-bit", sda_pull, 1'b0);
        do_stop();
    endtask

    task automatic t_rep_read();
        ten_mode = 1'b1; own_addr = 10'h2B5; addr_mask = '0;
        do_stop();
        do_start(); send_byte(8'hF5);
        chk("R9 read without write nack", sda_pull, 1'b0);
        do_start(); send_byte(8'hF4); send_bit(1'b0);
        send_byte(8'hB5); send_bit(1'b0);
        do_start(); send_byte(8'hF5);
        chk("R9 repeated read ack", sda_pull, 1'b1);
        chk("R9 repeated read match", addr_match, 1'b1);
        chk("R9 repeated read rw", rw_flag, 1'b1);
        do_start(); send_byte(8'hF4); send_bit(1'b0);
        send_byte(8'hB5); send_bit(1'b0);
        do_stop(); do_start(); send_byte(8'hF5);
        chk("R11 stop forgets 10-bit write", sda_pull, 1'b0);
        do_stop();
    endtask

    task automatic t_clear();
        ten_mode = 1'b0; own_addr = 10'h02A; addr_mask = '0;
        do_start(); send_byte(8'h55);
        do_stop();
        chk("R11 stop clears match", addr_match, 1'b0);
        chk("R11 stop clears rw", rw_flag, 1'b0);
        chk("R11 stop clears pull", sda_pull, 1'b0);
        send_byte(8'h54);
        chk("R11 bits after stop ignored", sda_pull, 1'b0);
        do_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        do_start(); send_byte(8'h54);
        chk("R11 partial byte dropped", addr_match, 1'b1);
        do_start();
        chk("R11 start clears match", addr_match, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_seven_exact();
        t_mask();
        t_mask_off();
        t_reserved();
        t_gcall();
        t_ten_bit();
        t_ten_reserved();
        t_rep_read();
        t_clear();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule